// File: doc/BRIEF.md
# SD Card Command Controller

This block is a processor-mapped peripheral that issues SD-protocol command frames on the card's single-wire command line and captures the card's short reply. Software loads a 32-bit argument register first. It then writes the 6-bit command number, and that write starts the transfer. The controller latches the command for one cycle. It then runs a bit-serial CRC7 over the first 40 frame bits and shifts out the 48-bit frame. Outgoing bits change on the falling edge of the generated card clock.

After the end bit, the controller releases the line and samples it on rising card-clock edges. It waits for a start bit and collects a 48-bit short response. The 32-bit payload is kept, and a ready flag is raised for software to poll. Reading the payload clears the flag. If no start bit arrives within a fixed number of card clocks, the command ends with a timeout flag instead. Register writes are dropped while a command is in flight.

Top module: `sd_cmd_ctrl`

## Requirements
- R1: After reset the status word (register 3) reads 0, the response word (register 2) reads 0, `cmd_oe` is 0 and `cmd_out` is 1.
- R2: A write of `bus_wdata[5:0]` to register 1 while idle starts a command. The busy flag, status bit 1, is set from that write until the command ends.
- R3: The frame is sent MSB first, one bit per card-clock period: 0, 1, the 6-bit command number, the 32-bit argument last written to register 0, a 7-bit CRC, then 1. `cmd_oe` is high for exactly these 48 bits.
- R4: The CRC uses the polynomial x^7+x^3+1 with zero start value, taken over the first 40 frame bits. It always covers the command number of the current write, even when commands follow back to back. For command 0 with argument 0 the CRC is 7'h4A.
- R5: `cmd_out` and `cmd_oe` change only in the cycle in which `sd_clk` falls, so the bit is stable across every rising card-clock edge.
- R6: After the frame, `cmd_in` is sampled on rising card-clock edges. Idle 1 bits before the first 0 start bit are skipped. The 32 bits that follow the 2 header bits and the 6-bit index of the reply become the payload. The trailing CRC and end bit are ignored. Completion sets ready (status bit 0) and clears busy.
- R7: A read of register 2 returns the payload and clears ready. Reading register 3 leaves ready unchanged.
- R8: If no start bit is seen within 64 rising card-clock edges after the frame, busy clears, the timeout flag (status bit 2) is set and ready stays 0. A new command clears the timeout flag.
- R9: While busy, writes to register 0 and register 1 have no effect on the argument, on the command number, or on starting a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 2 | Register select: 0 argument, 1 command, 2 response, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |

## Verification
The bench sends commands with different numbers back to back. A controller that computed the CRC before latching the new number would send the CRC of the previous command. Replies are preceded by a varying number of idle high bits, so a receiver that counted from the end of the frame, rather than from the start bit, would return a shifted payload. Each frame bit is sampled just after the rising card edge and again just before the falling edge, which exposes a driver that switches on the wrong edge. Further tests cover writes made while busy, a silent card that must time out, and a status read that must not clear ready.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  localparam int FRAME_W = 48;
  localparam int CRC_IN_W = 40;
  localparam int RX_SR_W = 40;

  localparam logic [1:0] REG_ARG  = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_RESP = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_CRC,
    ST_SEND,
    ST_WAIT
  } ctrl_state_t;

  // One bit of CRC7, polynomial x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_step(input logic [6:0] crc, input logic b);
    logic fb;
    fb = b ^ crc[6];
    return {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  // The first 40 frame bits: start 0, direction 1, index, argument.
  function automatic logic [CRC_IN_W-1:0] frame_head(input logic [5:0] idx,
                                                     input logic [31:0] arg);
    return {2'b01, idx, arg};
  endfunction

  function automatic logic [FRAME_W-1:0] frame_full(input logic [CRC_IN_W-1:0] head,
                                                    input logic [6:0] crc);
    return {head, crc, 1'b1};
  endfunction

  // The register holds the last 40 reply bits. Its top 32 bits are the payload.
  function automatic logic [31:0] resp_payload(input logic [RX_SR_W-1:0] sr);
    return sr[39:8];
  endfunction

endpackage

// File: rtl/sdc_clkgen.sv
module sdc_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sd_clk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic tick;

  assign tick     = (cnt == LAST);
  assign rise_evt = tick && !sd_clk;
  assign fall_evt = tick && sd_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sd_clk <= 1'b0;
    end else if (tick) begin
      cnt    <= '0;
      sd_clk <= ~sd_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  rise_lands_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> sd_clk);

endmodule

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] data,
  output logic          done,
  output logic [6:0]    crc
);
  import sdc_pkg::*;

  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  logic [DW-1:0]    sh;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      crc  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh  <= data;
        cnt <= '0;
        run <= 1'b1;
        crc <= '0;
      end else if (run) begin
        crc <= crc7_step(crc, sh[DW-1]);
        sh  <= sh << 1;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));

endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx #(
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        rise_evt,
  input  logic        cmd_in,
  output logic        done,
  output logic        timed_out,
  output logic [31:0] payload
);
  import sdc_pkg::*;

  localparam int WTW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [WTW-1:0] WLAST = WTW'(TIMEOUT - 1);
  localparam logic [5:0] BLAST = 6'(FRAME_W - 1);

  logic               receiving;
  logic [5:0]         bit_cnt;
  logic [WTW-1:0]     wait_cnt;
  logic [RX_SR_W-1:0] sr;
  logic [RX_SR_W-1:0] sr_next;

  assign sr_next = {sr[RX_SR_W-2:0], cmd_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      receiving <= 1'b0;
      bit_cnt   <= '0;
      wait_cnt  <= '0;
      sr        <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      payload   <= '0;
    end else begin
      done      <= 1'b0;
      timed_out <= 1'b0;
      if (!arm) begin
        receiving <= 1'b0;
        bit_cnt   <= '0;
        wait_cnt  <= '0;
      end else if (rise_evt) begin
        if (!receiving) begin
          if (!cmd_in) begin
            receiving <= 1'b1;
            bit_cnt   <= 6'd1;
            sr        <= '0;
          end else if (wait_cnt == WLAST) begin
            timed_out <= 1'b1;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end else begin
          sr      <= sr_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == BLAST) begin
            receiving <= 1'b0;
            done      <= 1'b1;
            payload   <= resp_payload(sr_next);
          end
        end
      end
    end
  end

  // R8
  end_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timed_out) |-> !(done && timed_out));

  // R6
  done_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(receiving));

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl #(
  parameter int HALF_DIV     = 2,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sd_clk,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  import sdc_pkg::*;

  localparam logic [5:0] TX_LAST = 6'(FRAME_W);

  ctrl_state_t        state;
  logic [31:0]        arg_q;
  logic [5:0]         idx_q;
  logic [31:0]        resp_q;
  logic               ready_q;
  logic               tmo_q;
  logic [FRAME_W-1:0] frame_q;
  logic [5:0]         tx_cnt;

  // Named internal events.
  logic busy;
  logic wr_arg;
  logic wr_cmd;
  logic rd_resp;
  logic trigger;
  logic rise_evt;
  logic fall_evt;
  logic crc_done;
  logic [6:0] crc_val;
  logic rx_done;
  logic rx_tmo;
  logic [31:0] rx_payload;

  assign busy    = (state != ST_IDLE);
  assign wr_arg  = bus_wr && (bus_addr == REG_ARG);
  assign wr_cmd  = bus_wr && (bus_addr == REG_CMD);
  assign rd_resp = bus_rd && (bus_addr == REG_RESP);
  assign trigger = wr_cmd && !busy;

  sdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_clk   (sd_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  sdc_crc7 #(.DW(CRC_IN_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (state == ST_LATCH),
    .data  (frame_head(idx_q, arg_q)),
    .done  (crc_done),
    .crc   (crc_val)
  );

  sdc_resp_rx #(.TIMEOUT(RESP_TIMEOUT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (state == ST_WAIT),
    .rise_evt  (rise_evt),
    .cmd_in    (cmd_in),
    .done      (rx_done),
    .timed_out (rx_tmo),
    .payload   (rx_payload)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_q <= '0;
    end else if (wr_arg && !busy) begin
      arg_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      resp_q  <= '0;
      ready_q <= 1'b0;
      tmo_q   <= 1'b0;
      frame_q <= '0;
      tx_cnt  <= '0;
      cmd_out <= 1'b1;
      cmd_oe  <= 1'b0;
    end else begin
      if (rd_resp) ready_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trigger) begin
            idx_q <= bus_wdata[5:0];
            tmo_q <= 1'b0;
            state <= ST_LATCH;
          end
        end
        ST_LATCH: state <= ST_CRC;
        ST_CRC: begin
          if (crc_done) begin
            frame_q <= frame_full(frame_head(idx_q, arg_q), crc_val);
            tx_cnt  <= '0;
            state   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fall_evt) begin
            if (tx_cnt == TX_LAST) begin
              cmd_oe  <= 1'b0;
              cmd_out <= 1'b1;
              state   <= ST_WAIT;
            end else begin
              cmd_oe  <= 1'b1;
              cmd_out <= frame_q[FRAME_W-1];
              frame_q <= frame_q << 1;
              tx_cnt  <= tx_cnt + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (rx_done) begin
            resp_q  <= rx_payload;
            ready_q <= 1'b1;
            state   <= ST_IDLE;
          end else if (rx_tmo) begin
            tmo_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_RESP: bus_rdata = resp_q;
      REG_STAT: bus_rdata = {29'b0, tmo_q, busy, ready_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (state == ST_LATCH));

  // R4
  latch_then_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LATCH) |=> (state == ST_CRC) && $stable(idx_q));

  // R5
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(cmd_out) && $stable(cmd_oe));

  // R6
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(rx_done));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp && !rx_done) |=> !ready_q);

  // R9
  busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(arg_q) && $stable(idx_q));

endmodule

// File: tb/test_sd_cmd_ctrl.sv
`timescale 1ns/1ps
module test_sd_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sd_clk;
  logic        cmd_out;
  logic        cmd_oe;
  logic        cmd_in = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sd_cmd_ctrl i_sd_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  // Vector: {gap[3:0], payload[31:0], arg[31:0], idx[5:0]}
  localparam logic [73:0] VEC [5] = '{
    {4'd1, 32'h0000_01AA, 32'h0000_0000, 6'd0},
    {4'd3, 32'h0000_01AA, 32'h0000_01AA, 6'd8},
    {4'd2, 32'h0012_3400, 32'h0000_0000, 6'd55},
    {4'd5, 32'hDEAD_BEEF, 32'h0000_0200, 6'd17},
    {4'd4, 32'h8000_0001, 32'hFFFF_FFFF, 6'd63}
  };

  // CRC7 by polynomial long division of the message times x^7.
  function automatic logic [6:0] crc_ref(input logic [39:0] d);
    logic [46:0] v;
    v = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
    return v[6:0];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Capture the 48 driven bits. Also count bits that moved within a high phase.
  task automatic grab_frame(output logic [47:0] f, output int unstable, output int oe_bits);
    logic a;
    unstable = 0; oe_bits = 0;
    wait (cmd_oe === 1'b1);
    for (int i = 47; i >= 0; i--) begin
      @(posedge sd_clk); #1 a = cmd_out;
      if (cmd_oe === 1'b1) oe_bits++;
      #7 if (cmd_out !== a) unstable++;
      f[i] = a;
    end
  endtask

  task automatic reply(input int gap, input logic [5:0] idx, input logic [31:0] pl);
    logic [47:0] rf;
    rf = {2'b00, idx, pl, crc_ref({2'b00, idx, pl}), 1'b1};
    while (cmd_oe === 1'b1) @(posedge clk);
    repeat (gap) @(negedge sd_clk);
    for (int i = 47; i >= 0; i--) begin
      @(negedge sd_clk); #1 cmd_in = rf[i];
    end
    @(negedge sd_clk); #1 cmd_in = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [47:0] fr;
    int unst, oeb;

    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    bus_read(2'd3, rd); chk("R1 status", rd, 0);
    bus_read(2'd2, rd); chk("R1 response", rd, 0);
    chk("R1 cmd_oe", cmd_oe, 0);
    chk("R1 cmd_out", cmd_out, 1);

    // Table walk: R2 R3 R4 R5 R6 R7
    foreach (VEC[k]) begin
      logic [5:0]  idx;
      logic [31:0] arg, pl;
      int gap;
      idx = VEC[k][5:0]; arg = VEC[k][37:6]; pl = VEC[k][69:38]; gap = int'(VEC[k][73:70]);
      bus_write(2'd0, arg);
      bus_write(2'd1, {26'b0, idx});
      bus_read(2'd3, rd); chk("R2 busy after trigger", rd[1], 1);
      grab_frame(fr, unst, oeb);
      chk("R3 frame", fr, {2'b01, idx, arg, crc_ref({2'b01, idx, arg}), 1'b1});
      chk("R3 oe span", oeb, 48);
      chk("R4 crc field", fr[7:1], crc_ref({2'b01, idx, arg}));
      if (idx == 6'd0 && arg == 32'd0) chk("R4 cmd0 crc", fr[7:1], 7'h4A);
      chk("R5 stable high phase", unst, 0);
      reply(gap, idx, pl);
      bus_read(2'd3, rd); chk("R6 status ready not busy", rd[2:0], 3'b001);
      bus_read(2'd3, rd); chk("R7 status read keeps ready", rd[0], 1);
      bus_read(2'd2, rd); chk("R6 payload", rd, pl);
      bus_read(2'd3, rd); chk("R7 ready cleared", rd[0], 0);
    end

    // R9 writes while busy are dropped
    bus_write(2'd0, 32'hA5A5_0001);
    bus_write(2'd1, 32'd12);
    bus_write(2'd0, 32'h5A5A_FFFF);
    bus_write(2'd1, 32'd40);
    grab_frame(fr, unst, oeb);
    chk("R9 busy writes ignored", fr,
        {2'b01, 6'd12, 32'hA5A5_0001, crc_ref({2'b01, 6'd12, 32'hA5A5_0001}), 1'b1});
    reply(1, 6'd12, 32'h0BAD_F00D);
    bus_read(2'd3, rd); chk("R9 no second command", rd[1], 0);
    bus_read(2'd2, rd); chk("R7 payload after busy writes", rd, 32'h0BAD_F00D);
    bus_write(2'd1, 32'd7);
    grab_frame(fr, unst, oeb);
    chk("R9 argument kept", fr[39:8], 32'hA5A5_0001);
    chk("R4 new index in crc", fr[7:1], crc_ref({2'b01, 6'd7, 32'hA5A5_0001}));

    // R8 silent card times out after 64 rising card edges
    while (cmd_oe === 1'b1) @(posedge clk);
    repeat (230) @(posedge clk);
    bus_read(2'd3, rd); chk("R8 still busy before limit", rd[1], 1);
    repeat (60) @(posedge clk);
    bus_read(2'd3, rd); chk("R8 timeout status", rd[2:0], 3'b100);
    bus_write(2'd1, 32'd1);
    bus_read(2'd3, rd); chk("R8 new command clears timeout", rd[2:1], 2'b01);
    grab_frame(fr, unst, oeb);
    reply(2, 6'd1, 32'h00FF_8000);
    bus_read(2'd2, rd); chk("R6 payload after timeout", rd, 32'h00FF_8000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule